// File: doc/BRIEF.md
# Augmented-Message Bit-Serial CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a byte stream. It processes one message bit per clock. It uses the augmented-message formulation. The first four bytes of a frame are not divided at all: each is stored, inverted, into its lane of the remainder register. Byte 0 goes to the top lane. Every later byte is shifted in most-significant bit first at the bottom of the register, while the feedback path acts on the register's top bit. The data therefore trails the division by 32 bit positions.

A transmitter appends four zero bytes where the check value will go. It then writes the four result bytes, most significant first, into that space. A receiver runs the whole frame, including those four bytes. A frame that arrived intact then gives a result of zero. Bytes arrive over a valid/ready handshake with start-of-frame and end-of-frame flags. The result appears with a one-cycle completion strobe. A frame too short to fill the preload raises a one-cycle error strobe and gives no result.

The controller has six states:
- `S_IDLE` waits for a start-of-frame byte.
- `S_PRE` collects the remaining preload bytes.
- `S_BODY` is ready for the next message byte.
- `S_SHIFT` spends eight cycles dividing that byte.
- `S_DONE` raises the completion strobe.
- `S_FAULT` raises the short-frame error strobe.

The transitions are:
- `S_IDLE` goes to `S_PRE` on start-of-frame, or to `S_FAULT` if that byte also ends the frame.
- `S_PRE` goes to `S_BODY` after the fourth byte, to `S_DONE` if the fourth byte ends the frame, or to `S_FAULT` on an earlier end.
- `S_BODY` goes to `S_SHIFT` on each accepted byte.
- `S_SHIFT` goes back to `S_BODY` after eight bits, or to `S_DONE` when the shifted byte carried end-of-frame.
- `S_DONE` and `S_FAULT` return to `S_IDLE`.
- A start-of-frame accepted in `S_PRE` or `S_BODY` restarts the frame and goes to `S_PRE`.

Top module: `crc32_aug_serial`

## Requirements
- R1: A synchronous reset clears the remainder, the bit counter and the preload counter. The next cycle shows `res_crc` = 32'hFFFFFFFF, `done` = 0, `err` = 0 and `in_ready` = 1.
- R2: The first four bytes of a frame are stored complemented into the remainder, byte 0 in bits 31..24 and byte 3 in bits 7..0. A frame of exactly four bytes B0..B3 therefore produces `res_crc` = {B0,B1,B2,B3}, with `done` high in the cycle after the edge that accepts B3.
- R3: Each later byte is shifted in MSB first. Each step shifts the register left by one and inserts the data bit at bit 0. When bit 31 was 1 before the step, 32'h04C11DB7 is XORed into the shifted value. The result is the complement of the final register. For example, "123456789" followed by four zero bytes gives 32'hFC891918.
- R4: A frame made of a message followed by its result bytes, most significant byte first, gives `res_crc` = 0.
- R5: `done` goes high exactly eight cycles after the clock edge that accepts an end-of-frame byte beyond the preload. `in_ready` is low in all eight of those cycles.
- R6: `done` is high for exactly one cycle. `res_crc` then holds its value until the next start-of-frame byte is accepted.
- R7: A frame that ends after one, two or three bytes raises `err` for one cycle, in the cycle after the edge that accepts its end-of-frame byte. `done` does not go high for such a frame.
- R8: While idle, a byte accepted without the start-of-frame flag is discarded and does not change the next frame's result. This holds even if the byte carries end-of-frame, and it raises neither `err` nor `done`.
- R9: A start-of-frame byte accepted in the middle of a frame abandons that frame and begins a new one. The new frame's result equals that of the same frame sent from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Message byte |
| in_sof | input | 1 | Offered byte is the first of a frame |
| in_eof | input | 1 | Offered byte is the last of a frame |
| in_ready | output | 1 | Block can take a byte this cycle |
| done | output | 1 | One-cycle strobe: `res_crc` is valid |
| err | output | 1 | One-cycle strobe: frame shorter than four bytes |
| res_crc | output | 32 | Complement of the remainder register |

## Verification
The riskiest corners are the boundaries between preload and division.

A frame of exactly four bytes must finish without any shift. An off-by-one in the preload counter would either shift one byte or fault it. Frames of one to three bytes must fault silently; a design that let them through would raise `done` with a partial remainder.

Lane order and the complement are pinned by the four-byte result and by a known check value. A swapped lane or a missing inversion changes every transmitted result and breaks the zero seen by the receiver.

The bench counts the eight-cycle window exactly, so an extra or missing shift shows as a misplaced `done`. It also sends stray bytes while idle, a start-of-frame in the middle of a frame, and a reset during shifting. A design that leaked state across any of these would produce a wrong final result.

// File: rtl/crc_aug_pkg.sv
package crc_aug_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_BODY,
        S_SHIFT,
        S_DONE,
        S_FAULT
    } crc_state_t;

endpackage

// File: rtl/crc_aug_ctrl.sv
module crc_aug_ctrl
    import crc_aug_pkg::*;
#(
    parameter int PRE_BYTES = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             last_bit,
    output logic             in_ready,
    output logic             pre_load,
    output logic [IDX_W-1:0] pre_idx,
    output logic             feed_load,
    output logic             shift_en,
    output logic             done,
    output logic             err
);

    crc_state_t       state_q, state_d;
    logic [IDX_W-1:0] pre_cnt_q;
    logic             eof_q;
    logic             take;
    logic             restart;
    logic             last_pre;

    assign last_pre = (pre_cnt_q == IDX_W'(PRE_BYTES - 1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take && in_sof) state_d = in_eof ? S_FAULT : S_PRE;
            end
            S_PRE: begin
                if (take) begin
                    if (in_sof)        state_d = in_eof ? S_FAULT : S_PRE;
                    else if (in_eof)   state_d = last_pre ? S_DONE : S_FAULT;
                    else if (last_pre) state_d = S_BODY;
                end
            end
            S_BODY: begin
                if (take) begin
                    if (in_sof) state_d = in_eof ? S_FAULT : S_PRE;
                    else        state_d = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (last_bit) state_d = eof_q ? S_DONE : S_BODY;
            end
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == S_IDLE) || (state_q == S_PRE) || (state_q == S_BODY);
        take      = in_valid && in_ready;
        restart   = take && in_sof;
        pre_load  = restart || (take && (state_q == S_PRE));
        pre_idx   = restart ? '0 : pre_cnt_q;
        feed_load = take && !in_sof && (state_q == S_BODY);
        shift_en  = (state_q == S_SHIFT);
        done      = (state_q == S_DONE);
        err       = (state_q == S_FAULT);
    end

    // preload counter and end-of-frame latch
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt_q <= '0;
            eof_q     <= 1'b0;
        end else begin
            if (restart)
                pre_cnt_q <= IDX_W'(1);
            else if (take && (state_q == S_PRE))
                pre_cnt_q <= pre_cnt_q + IDX_W'(1);
            else if ((state_q == S_DONE) || (state_q == S_FAULT))
                pre_cnt_q <= '0;
            if (feed_load)
                eof_q <= in_eof;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                   // R6
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);                                     // R7
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && err));                                   // R7

endmodule

// File: rtl/crc_aug_feed.sv
module crc_aug_feed #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              shift_en,
    output logic              bit_out,
    output logic              last_bit
);

    logic [BYTE_W-1:0] sreg_q;
    logic [CNT_W-1:0]  bcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            bcnt_q <= '0;
        end else if (load) begin
            sreg_q <= load_byte;
            bcnt_q <= '0;
        end else if (shift_en) begin
            sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
            bcnt_q <= bcnt_q + CNT_W'(1);
        end
    end

    assign bit_out  = sreg_q[BYTE_W-1];
    assign last_bit = shift_en && (bcnt_q == CNT_W'(BYTE_W - 1));

    AST_NO_LOAD_MID_BYTE: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !last_bit) |=> !load);                // R5

endmodule

// File: rtl/crc_aug_rem.sv
module crc_aug_rem #(
    parameter int              CRC_W  = 32,
    parameter int              BYTE_W = 8,
    parameter int              IDX_W  = 2,
    parameter logic [CRC_W-1:0] POLY  = 32'h04C11DB7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_load,
    input  logic [IDX_W-1:0]  pre_idx,
    input  logic [BYTE_W-1:0] pre_byte,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [CRC_W-1:0]  rem
);

    localparam int LANES = CRC_W / BYTE_W;

    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] load_val;
    logic [CRC_W-1:0] step_val;
    logic [LANES-1:0] lane_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int TOP = CRC_W - 1 - g * BYTE_W;
        assign lane_hit[g] = pre_load && (pre_idx == IDX_W'(g));
        assign load_val[TOP -: BYTE_W] = lane_hit[g] ? ~pre_byte : rem_q[TOP -: BYTE_W];
    end

    assign step_val = {rem_q[CRC_W-2:0], bit_in} ^ (rem_q[CRC_W-1] ? POLY : '0);

    always_ff @(posedge clk) begin
        if (rst)           rem_q <= '0;
        else if (pre_load) rem_q <= load_val;
        else if (shift_en) rem_q <= step_val;
    end

    assign rem = rem_q;

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_hit));                               // R2

endmodule

// File: rtl/crc32_aug_serial.sv
module crc32_aug_serial #(
    parameter int               CRC_W  = 32,
    parameter int               BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 32'h04C11DB7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              in_ready,
    output logic              done,
    output logic              err,
    output logic [CRC_W-1:0]  res_crc
);

    localparam int PRE_BYTES = CRC_W / BYTE_W;
    localparam int IDX_W     = (PRE_BYTES > 1) ? $clog2(PRE_BYTES) : 1;
    localparam int CNT_W     = $clog2(BYTE_W);

    logic             pre_load;
    logic [IDX_W-1:0] pre_idx;
    logic             feed_load;
    logic             shift_en;
    logic             last_bit;
    logic             bit_s;
    logic [CRC_W-1:0] rem;

    crc_aug_ctrl #(.PRE_BYTES(PRE_BYTES), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .last_bit(last_bit), .in_ready(in_ready),
        .pre_load(pre_load), .pre_idx(pre_idx), .feed_load(feed_load),
        .shift_en(shift_en), .done(done), .err(err)
    );

    crc_aug_feed #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_feed (
        .clk(clk), .rst(rst), .load(feed_load), .load_byte(in_data),
        .shift_en(shift_en), .bit_out(bit_s), .last_bit(last_bit)
    );

    crc_aug_rem #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W), .POLY(POLY)) u_rem (
        .clk(clk), .rst(rst), .pre_load(pre_load), .pre_idx(pre_idx),
        .pre_byte(in_data), .shift_en(shift_en), .bit_in(bit_s), .rem(rem)
    );

    assign res_crc = ~rem;

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(res_crc));                        // R6
    AST_QUIET_WHILE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        shift_en |-> !in_ready);                           // R5

endmodule

// File: tb/sim_crc32_aug_serial.sv
module sim_crc32_aug_serial;

    localparam int CLK_P = 10;
    localparam logic [31:0] POLY = 32'h04C11DB7;
    localparam int NV = 4;
    localparam logic [95:0] VMSG [0:NV-1] = '{
        96'h31323334_35363738_39000000,
        96'hA5000000_00000000_00000000,
        96'hFFFFFFFF_01234567_89ABCDEF,
        96'h800100FE_7F000000_00000000
    };
    localparam int VLEN [0:NV-1] = '{9, 1, 12, 5};
    localparam logic [31:0] VKNOWN [0:NV-1] = '{32'hFC891918, 32'h0, 32'h0, 32'h0};
    localparam logic        VHASK  [0:NV-1] = '{1'b1, 1'b0, 1'b0, 1'b0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        in_ready, done, err;
    logic [31:0] res_crc;

    int checks = 0;
    int fails  = 0;
    logic [7:0] fb [0:31];
    logic [31:0] got, want, held;

    crc32_aug_serial u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
        .done(done), .err(err), .res_crc(res_crc)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(int n);
        logic [31:0] r;
        logic        fbk;
        r = ~{fb[0], fb[1], fb[2], fb[3]};
        for (int i = 4; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                fbk = r[31];
                r = {r[30:0], fb[i][b]};
                if (fbk) r = r ^ POLY;
            end
        end
        return ~r;
    endfunction

    task automatic send(logic [7:0] d, logic s, logic e);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    // sends fb[0..n-1] as a frame and returns the result at the done cycle
    task automatic run_frame(int n, string tag, output logic [31:0] crc);
        logic quiet;
        for (int i = 0; i < n; i++) send(fb[i], i == 0, i == n - 1);
        if (n > 4) begin
            quiet = 1'b1;
            for (int k = 0; k < 8; k++) begin
                if (k > 0) @(negedge clk);
                if (done || in_ready) quiet = 1'b0;
            end
            chk({tag, " R5 quiet window"}, {31'd0, quiet}, 32'd1);
            @(negedge clk);
        end
        chk({tag, " R5 done timing"}, {31'd0, done}, 32'd1);
        crc = res_crc;
    endtask

    task automatic load_msg(int v, int extra);
        for (int i = 0; i < 12; i++) fb[i] = VMSG[v][95 - 8*i -: 8];
        for (int i = 0; i < extra; i++) fb[VLEN[v] + i] = 8'h00;
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset crc", res_crc, 32'hFFFFFFFF);
        chk("R1 reset strobes", {30'd0, done, err}, 32'd0);
        chk("R1 reset ready", {31'd0, in_ready}, 32'd1);

        // vector table: transmit then receive each message
        for (int v = 0; v < NV; v++) begin
            load_msg(v, 4);
            want = model(VLEN[v] + 4);
            run_frame(VLEN[v] + 4, "R3 tx", got);
            chk("R3 tx result", got, want);
            if (VHASK[v]) chk("R3 known value", got, VKNOWN[v]);
            @(negedge clk);
            chk("R6 done one cycle", {31'd0, done}, 32'd0);
            held = res_crc;
            repeat (3) @(negedge clk);
            chk("R6 result holds", res_crc, held);
            load_msg(v, 0);
            fb[VLEN[v]]     = got[31:24];
            fb[VLEN[v] + 1] = got[23:16];
            fb[VLEN[v] + 2] = got[15:8];
            fb[VLEN[v] + 3] = got[7:0];
            run_frame(VLEN[v] + 4, "R4 rx", got);
            chk("R4 rx zero", got, 32'h0);
        end

        // exactly four bytes: preload only
        fb[0] = 8'hDE; fb[1] = 8'hAD; fb[2] = 8'hBE; fb[3] = 8'hEF;
        run_frame(4, "R2 four", got);
        chk("R2 preload lanes", got, 32'hDEADBEEF);

        // short frames
        for (int n = 1; n < 4; n++) begin
            for (int i = 0; i < n; i++) send(8'h40 + 8'(i), i == 0, i == n - 1);
            chk("R7 short err", {30'd0, err, done}, 32'd2);
            @(negedge clk);
            chk("R7 no late done", {30'd0, err, done}, 32'd0);
        end

        // stray bytes while idle
        send(8'h55, 1'b0, 1'b0);
        chk("R8 stray no strobe", {30'd0, err, done}, 32'd0);
        send(8'h11, 1'b0, 1'b1);
        chk("R8 stray eof no strobe", {30'd0, err, done}, 32'd0);
        load_msg(0, 4);
        run_frame(13, "R8 after stray", got);
        chk("R8 result unaffected", got, 32'hFC891918);

        // restart in preload and in body
        send(8'hAA, 1'b1, 1'b0);
        send(8'hBB, 1'b0, 1'b0);
        load_msg(3, 4);
        want = model(9);
        run_frame(9, "R9 restart pre", got);
        chk("R9 restart from preload", got, want);
        for (int i = 0; i < 6; i++) send(8'h3C ^ 8'(i), i == 0, 1'b0);
        run_frame(9, "R9 restart body", got);
        chk("R9 restart from body", got, want);

        // reset during shifting
        for (int i = 0; i < 5; i++) send(8'h77, i == 0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-frame reset crc", res_crc, 32'hFFFFFFFF);
        chk("R1 mid-frame reset ready", {29'd0, in_ready, done, err}, 32'd4);

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule